// File: doc/BRIEF.md
# Two-Thread Context-Sequenced Pixel VLIW Unit

This block is a small pixel processor with no instruction fetch. Each of two hardware threads owns a short stack of context words, written beforehand through a plain write port. Every cycle that carries a pixel slot runs one context word for the thread that owns that slot. Each word drives four function units side by side: a comparator, two general ALUs and a saturating multiplier. The thread's step pointer then moves on and wraps after the last layer, so one pixel is processed by a fixed sequence of layers spread over that thread's slots.

Operands for every unit come from per-unit input selectors. Each selector picks the pixel on the slot, an auxiliary value from a neighbouring stage, or one of two reads from the thread's private register bank. An output multiplexer forwards one unit's result. The same instruction can also write one unit's result back into the bank. Because the two threads keep separate pointers and banks, two independent pixel streams can share the hardware by alternating slots.

Top module: `pixel_vliw_alu`

## Requirements
- R1: While reset is low and after its release, outValid, outLast and outPixel are 0, every context word is zero, every step pointer is 0 and every register-bank entry is 0. An all-zero word outputs the slot pixel unchanged, as the minimum of the pixel with itself.
- R2: A cycle with ctxWrEn high stores ctxWrData as the word of layer ctxWrLayer of thread ctxWrThread. The 43-bit word is laid out from bit 42 down as: outSel[2], wrEn[1], wrAddr[4], wrSel[2], raA[4], raB[4], cmpOp[3], cmpA[2], cmpB[2], alu0Op[2], alu0A[2], alu0B[2], mulSh[3], mulA[2], mulB[2], alu1Op[2], alu1A[2], alu1B[2].
- R3: Each thread has its own step pointer over 4 layers. A valid slot for thread t runs layer pointer(t) and then advances that pointer, wrapping from 3 to 0. outLast marks a result produced by layer 3. Slots of one thread never move the other thread's pointer.
- R4: Operand select codes are 0 = slot pixel (inPixel), 1 = inAux, 2 = bank entry raA, 3 = bank entry raB. The bank read is always from the thread that owns the slot.
- R5: The comparator op codes are 000 = minimum, 001 = maximum, 010 = 1 if A > B else 0, 011 = 1 if A == B else 0, 100 = |A - B|. The codes 101 to 111 give 0.
- R6: Both ALUs use the op codes 00 = A + B clamped to 255, 01 = A - B clamped to 0, 10 = bitwise AND, 11 = bitwise XOR.
- R7: The multiplier forms the 16-bit product A*B, shifts it right by mulSh (0 to 7) and clamps the result to 255.
- R8: outSel and wrSel both use the codes 0 = comparator, 1 = ALU0, 2 = multiplier, 3 = ALU1. On the clock edge after a valid slot, outValid is 1, outThread equals that slot's thread and outPixel holds the selected result.
- R9: With wrEn set, the unit picked by wrSel is written into entry wrAddr of the slot thread's bank. A read in the same instruction still returns the old value. The next instruction of the same thread reads the new value. The other thread's bank is left unchanged.
- R10: A cycle with inValid low changes no step pointer or bank entry. On the following edge outValid is 0 and outPixel keeps its previous value, even when a context write happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctxWrEn | input | 1 | Context word write strobe |
| ctxWrThread | input | 1 | Thread whose context is written |
| ctxWrLayer | input | 2 | Layer index written |
| ctxWrData | input | 43 | Context word |
| inValid | input | 1 | A slot is present this cycle |
| inThread | input | 1 | Thread owning the slot |
| inPixel | input | 8 | Slot pixel |
| inAux | input | 8 | Value from a neighbouring stage |
| outValid | output | 1 | Result present |
| outThread | output | 1 | Thread of the result |
| outLast | output | 1 | Result came from the last layer |
| outPixel | output | 8 | Selected result |

## Verification
The sweeps target the edges of the arithmetic. Operand pairs at 0, 1, 127, 128, 254 and 255, together with equal pairs, catch an add or multiply that wraps instead of clamping, a subtract that underflows, a swapped min and max, and flags that fire on the wrong relation. The reserved comparator codes must give zero. Write-back is checked for same-instruction read-old behaviour and for isolation between the two banks; a design that forwards the new value, or shares one bank, returns the wrong pixel. Random programs run on unevenly interleaved slots, with idle cycles and context writes mixed in. They expose a shared step pointer, a pointer that moves on idle cycles, and an output that changes while idle.

// File: rtl/pva_pkg.sv
package pva_pkg;
  parameter int PIX_W    = 8;
  parameter int RF_DEPTH = 16;
  parameter int LAYERS   = 4;
  parameter int THREADS  = 2;

  localparam int RA_W = $clog2(RF_DEPTH);
  localparam int LY_W = $clog2(LAYERS);
  localparam int TH_W = (THREADS > 1) ? $clog2(THREADS) : 1;

  // operand source codes
  localparam logic [1:0] SRC_PIX = 2'd0;
  localparam logic [1:0] SRC_AUX = 2'd1;
  localparam logic [1:0] SRC_RFA = 2'd2;
  localparam logic [1:0] SRC_RFB = 2'd3;

  // function unit indices for output and write-back selection
  localparam int FU_CMP  = 0;
  localparam int FU_ALU0 = 1;
  localparam int FU_MUL  = 2;
  localparam int FU_ALU1 = 3;
  localparam int NUM_FU  = 4;
  localparam int NUM_ALU = 2;

  // comparator operations
  localparam logic [2:0] CMP_MIN = 3'd0;
  localparam logic [2:0] CMP_MAX = 3'd1;
  localparam logic [2:0] CMP_GT  = 3'd2;
  localparam logic [2:0] CMP_EQ  = 3'd3;
  localparam logic [2:0] CMP_ABD = 3'd4;

  // ALU operations
  localparam logic [1:0] ALU_ADDS = 2'd0;
  localparam logic [1:0] ALU_SUBS = 2'd1;
  localparam logic [1:0] ALU_AND  = 2'd2;
  localparam logic [1:0] ALU_XOR  = 2'd3;

  typedef struct packed {
    logic [1:0]      outSel;
    logic            wrEn;
    logic [RA_W-1:0] wrAddr;
    logic [1:0]      wrSel;
    logic [RA_W-1:0] raA;
    logic [RA_W-1:0] raB;
    logic [2:0]      cmpOp;
    logic [1:0]      cmpA;
    logic [1:0]      cmpB;
    logic [1:0]      alu0Op;
    logic [1:0]      alu0A;
    logic [1:0]      alu0B;
    logic [2:0]      mulSh;
    logic [1:0]      mulA;
    logic [1:0]      mulB;
    logic [1:0]      alu1Op;
    logic [1:0]      alu1A;
    logic [1:0]      alu1B;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  // control-to-datapath strobes
  typedef struct packed {
    logic            exec;
    logic [TH_W-1:0] thread;
    logic            last;
    instr_t          instr;
  } strobe_t;
endpackage

// File: rtl/pva_alu_unit.sv
module pva_alu_unit
  import pva_pkg::*;
(
  input  logic [1:0]       op,
  input  logic [PIX_W-1:0] a,
  input  logic [PIX_W-1:0] b,
  output logic [PIX_W-1:0] y
);
  logic [PIX_W:0] sum;

  assign sum = {1'b0, a} + {1'b0, b};

  always_comb begin
    unique case (op)
      ALU_ADDS: y = sum[PIX_W] ? '1 : sum[PIX_W-1:0];
      ALU_SUBS: y = (a > b) ? (a - b) : '0;
      ALU_AND:  y = a & b;
      default:  y = a ^ b;
    endcase
  end
endmodule

// File: rtl/pva_ctrl.sv
module pva_ctrl
  import pva_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctxWrEn,
  input  logic [TH_W-1:0]    ctxWrThread,
  input  logic [LY_W-1:0]    ctxWrLayer,
  input  logic [INSTR_W-1:0] ctxWrData,
  input  logic               inValid,
  input  logic [TH_W-1:0]    inThread,
  output strobe_t            stb
);
  localparam logic [LY_W-1:0] LAST_IP = LY_W'(LAYERS - 1);

  instr_t          ctxMem [THREADS][LAYERS];
  logic [LY_W-1:0] ipReg  [THREADS];
  logic [LY_W-1:0] curIp;

  assign curIp = ipReg[inThread];

  // context layers, loaded through the write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++)
        for (int l = 0; l < LAYERS; l++)
          ctxMem[t][l] <= '0;
    end else if (ctxWrEn) begin
      ctxMem[ctxWrThread][ctxWrLayer] <= instr_t'(ctxWrData);
    end
  end

  // per-thread step pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) ipReg[t] <= '0;
    end else if (inValid) begin
      ipReg[inThread] <= (curIp == LAST_IP) ? '0 : curIp + 1'b1;
    end
  end

  always_comb begin
    stb.exec   = inValid;
    stb.thread = inThread;
    stb.last   = (curIp == LAST_IP);
    stb.instr  = ctxMem[inThread][curIp];
  end
endmodule

// File: rtl/pva_datapath.sv
module pva_datapath
  import pva_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [PIX_W-1:0] inPixel,
  input  logic [PIX_W-1:0] inAux,
  output logic             outValid,
  output logic [TH_W-1:0]  outThread,
  output logic             outLast,
  output logic [PIX_W-1:0] outPixel
);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;
  localparam int PROD_W = 2 * PIX_W;

  logic [PIX_W-1:0] rfMem [THREADS][RF_DEPTH];
  instr_t           ins;
  logic [PIX_W-1:0] rdA, rdB;
  logic [PIX_W-1:0] cmpA, cmpB, cmpY;
  logic [PIX_W-1:0] mulA, mulB, mulY;
  logic [PROD_W-1:0] mulProd, mulShift;
  logic [1:0]       aluOp [NUM_ALU];
  logic [PIX_W-1:0] aluA  [NUM_ALU];
  logic [PIX_W-1:0] aluB  [NUM_ALU];
  logic [PIX_W-1:0] aluY  [NUM_ALU];
  logic [PIX_W-1:0] fuRes [NUM_FU];
  logic [PIX_W-1:0] selY, wrY;

  assign ins = stb.instr;
  assign rdA = rfMem[stb.thread][ins.raA];
  assign rdB = rfMem[stb.thread][ins.raB];

  function automatic logic [PIX_W-1:0] pickSrc(input logic [1:0] sel,
                                               input logic [PIX_W-1:0] px,
                                               input logic [PIX_W-1:0] ax,
                                               input logic [PIX_W-1:0] ra,
                                               input logic [PIX_W-1:0] rb);
    case (sel)
      SRC_PIX: return px;
      SRC_AUX: return ax;
      SRC_RFA: return ra;
      default: return rb;
    endcase
  endfunction

  // comparator unit
  always_comb begin
    cmpA = pickSrc(ins.cmpA, inPixel, inAux, rdA, rdB);
    cmpB = pickSrc(ins.cmpB, inPixel, inAux, rdA, rdB);
    case (ins.cmpOp)
      CMP_MIN: cmpY = (cmpA < cmpB) ? cmpA : cmpB;
      CMP_MAX: cmpY = (cmpA > cmpB) ? cmpA : cmpB;
      CMP_GT:  cmpY = {{(PIX_W-1){1'b0}}, (cmpA > cmpB)};
      CMP_EQ:  cmpY = {{(PIX_W-1){1'b0}}, (cmpA == cmpB)};
      CMP_ABD: cmpY = (cmpA > cmpB) ? (cmpA - cmpB) : (cmpB - cmpA);
      default: cmpY = '0;
    endcase
  end

  // two general ALUs
  always_comb begin
    aluOp[0] = ins.alu0Op;
    aluA[0]  = pickSrc(ins.alu0A, inPixel, inAux, rdA, rdB);
    aluB[0]  = pickSrc(ins.alu0B, inPixel, inAux, rdA, rdB);
    aluOp[1] = ins.alu1Op;
    aluA[1]  = pickSrc(ins.alu1A, inPixel, inAux, rdA, rdB);
    aluB[1]  = pickSrc(ins.alu1B, inPixel, inAux, rdA, rdB);
  end

  for (genvar g = 0; g < NUM_ALU; g++) begin : g_alu
    pva_alu_unit u_alu (
      .op(aluOp[g]),
      .a (aluA[g]),
      .b (aluB[g]),
      .y (aluY[g])
    );
  end

  // multiplier with shift and clamp
  always_comb begin
    mulA     = pickSrc(ins.mulA, inPixel, inAux, rdA, rdB);
    mulB     = pickSrc(ins.mulB, inPixel, inAux, rdA, rdB);
    mulProd  = PROD_W'(mulA) * PROD_W'(mulB);
    mulShift = mulProd >> ins.mulSh;
    mulY     = (|mulShift[PROD_W-1:PIX_W]) ? PIX_MAX : mulShift[PIX_W-1:0];
  end

  always_comb begin
    fuRes[FU_CMP]  = cmpY;
    fuRes[FU_ALU0] = aluY[0];
    fuRes[FU_MUL]  = mulY;
    fuRes[FU_ALU1] = aluY[1];
    selY = fuRes[ins.outSel];
    wrY  = fuRes[ins.wrSel];
  end

  // register banks, one per thread
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++)
        for (int e = 0; e < RF_DEPTH; e++)
          rfMem[t][e] <= '0;
    end else if (stb.exec && ins.wrEn) begin
      rfMem[stb.thread][ins.wrAddr] <= wrY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      outThread <= '0;
      outLast   <= 1'b0;
      outPixel  <= '0;
    end else begin
      outValid <= stb.exec;
      if (stb.exec) begin
        outThread <= stb.thread;
        outLast   <= stb.last;
        outPixel  <= selY;
      end
    end
  end
endmodule

// File: rtl/pixel_vliw_alu.sv
module pixel_vliw_alu
  import pva_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctxWrEn,
  input  logic [TH_W-1:0]    ctxWrThread,
  input  logic [LY_W-1:0]    ctxWrLayer,
  input  logic [INSTR_W-1:0] ctxWrData,
  input  logic               inValid,
  input  logic [TH_W-1:0]    inThread,
  input  logic [PIX_W-1:0]   inPixel,
  input  logic [PIX_W-1:0]   inAux,
  output logic               outValid,
  output logic [TH_W-1:0]    outThread,
  output logic               outLast,
  output logic [PIX_W-1:0]   outPixel
);
  strobe_t stb;

  pva_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctxWrEn    (ctxWrEn),
    .ctxWrThread(ctxWrThread),
    .ctxWrLayer (ctxWrLayer),
    .ctxWrData  (ctxWrData),
    .inValid    (inValid),
    .inThread   (inThread),
    .stb        (stb)
  );

  pva_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .inPixel  (inPixel),
    .inAux    (inAux),
    .outValid (outValid),
    .outThread(outThread),
    .outLast  (outLast),
    .outPixel (outPixel)
  );
endmodule

// File: rtl/pva_checker.sv
module pva_checker
  import pva_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic [TH_W-1:0]  inThread,
  input logic             outValid,
  input logic [TH_W-1:0]  outThread,
  input logic             outLast,
  input logic [PIX_W-1:0] outPixel
);
  int unsigned slotCnt [THREADS];
  logic        expLastQ;

  // independent slot counter per thread, used to predict outLast
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) slotCnt[t] <= 0;
      expLastQ <= 1'b0;
    end else if (inValid) begin
      expLastQ <= (slotCnt[inThread] == LAYERS - 1);
      slotCnt[inThread] <= (slotCnt[inThread] == LAYERS - 1) ? 0 : slotCnt[inThread] + 1;
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  assert_thread_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (outThread == $past(inThread)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && $stable(outPixel)));

  assert_last_layer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outLast == expLastQ));
endmodule

bind pixel_vliw_alu pva_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inThread (inThread),
  .outValid (outValid),
  .outThread(outThread),
  .outLast  (outLast),
  .outPixel (outPixel)
);

// File: tb/pixel_vliw_alu_bench.sv
`timescale 1ns/1ps
module pixel_vliw_alu_bench;
  import pva_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               ctxWrEn = 1'b0;
  logic [TH_W-1:0]    ctxWrThread = '0;
  logic [LY_W-1:0]    ctxWrLayer = '0;
  logic [INSTR_W-1:0] ctxWrData = '0;
  logic               inValid = 1'b0;
  logic [TH_W-1:0]    inThread = '0;
  logic [PIX_W-1:0]   inPixel = '0;
  logic [PIX_W-1:0]   inAux = '0;
  logic               outValid;
  logic [TH_W-1:0]    outThread;
  logic               outLast;
  logic [PIX_W-1:0]   outPixel;

  always #2 clk = ~clk;

  pixel_vliw_alu u_pixel_vliw_alu (
    .clk(clk), .rst_n(rst_n), .ctxWrEn(ctxWrEn), .ctxWrThread(ctxWrThread),
    .ctxWrLayer(ctxWrLayer), .ctxWrData(ctxWrData), .inValid(inValid),
    .inThread(inThread), .inPixel(inPixel), .inAux(inAux), .outValid(outValid),
    .outThread(outThread), .outLast(outLast), .outPixel(outPixel)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  instr_t mCtx [THREADS][LAYERS];
  int     mIp  [THREADS];
  int     mRf  [THREADS][RF_DEPTH];

  bit    pend = 0;
  bit    idleArmed = 0;
  int    expPix, expThr, lastOut;
  bit    expLast;
  string expTag;
  string forceTag = "";
  logic [31:0] rnd = 32'h1234_5679;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int srcVal(input logic [1:0] s, input int px, input int ax,
                                input int ra, input int rb);
    case (s)
      2'd0: return px;
      2'd1: return ax;
      2'd2: return ra;
      default: return rb;
    endcase
  endfunction

  function automatic int cmpRef(input int op, input int a, input int b);
    case (op)
      0: return (a < b) ? a : b;
      1: return (a > b) ? a : b;
      2: return (a > b) ? 1 : 0;
      3: return (a == b) ? 1 : 0;
      4: return (a > b) ? a - b : b - a;
      default: return 0;
    endcase
  endfunction

  function automatic int aluRef(input int op, input int a, input int b);
    case (op)
      0: return (a + b > 255) ? 255 : a + b;
      1: return (a > b) ? a - b : 0;
      2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic int mulRef(input int sh, input int a, input int b);
    int p;
    p = (a * b) >> sh;
    return (p > 255) ? 255 : p;
  endfunction

  function automatic string tagFor(input int sel);
    case (sel)
      0: return "R5 compare result";
      2: return "R7 multiply result";
      default: return "R6 alu result";
    endcase
  endfunction

  function automatic void modelStep(input int t, input int px, input int ax);
    instr_t w;
    int ra, rb;
    int fu [NUM_FU];
    w  = mCtx[t][mIp[t]];
    ra = mRf[t][w.raA];
    rb = mRf[t][w.raB];
    fu[0] = cmpRef(int'(w.cmpOp), srcVal(w.cmpA, px, ax, ra, rb), srcVal(w.cmpB, px, ax, ra, rb));
    fu[1] = aluRef(int'(w.alu0Op), srcVal(w.alu0A, px, ax, ra, rb), srcVal(w.alu0B, px, ax, ra, rb));
    fu[2] = mulRef(int'(w.mulSh), srcVal(w.mulA, px, ax, ra, rb), srcVal(w.mulB, px, ax, ra, rb));
    fu[3] = aluRef(int'(w.alu1Op), srcVal(w.alu1A, px, ax, ra, rb), srcVal(w.alu1B, px, ax, ra, rb));
    expPix  = fu[w.outSel];
    expThr  = t;
    expLast = (mIp[t] == LAYERS - 1);
    expTag  = (forceTag != "") ? forceTag : tagFor(int'(w.outSel));
    if (w.wrEn) mRf[t][w.wrAddr] = fu[w.wrSel];
    mIp[t] = (mIp[t] == LAYERS - 1) ? 0 : mIp[t] + 1;
  endfunction

  task automatic checkPending();
    if (pend) begin
      check(outValid == 1'b1, "R8 outValid after slot", int'(outValid), 1);
      check(int'(outThread) == expThr, "R8 outThread", int'(outThread), expThr);
      check(outLast == expLast, "R3 outLast", int'(outLast), int'(expLast));
      check(int'(outPixel) == expPix, expTag, int'(outPixel), expPix);
      lastOut = expPix;
    end else if (idleArmed) begin
      check(outValid == 1'b0, "R10 outValid idle", int'(outValid), 0);
      check(int'(outPixel) == lastOut, "R10 outPixel hold", int'(outPixel), lastOut);
    end
  endtask

  task automatic issue(input int t, input int px, input int ax);
    @(negedge clk);
    checkPending();
    ctxWrEn  = 1'b0;
    inValid  = 1'b1;
    inThread = TH_W'(t);
    inPixel  = PIX_W'(px);
    inAux    = PIX_W'(ax);
    modelStep(t, px, ax);
    pend = 1;
    idleArmed = 1;
  endtask

  task automatic idleCycle();
    @(negedge clk);
    checkPending();
    ctxWrEn = 1'b0;
    inValid = 1'b0;
    pend = 0;
  endtask

  task automatic loadCtx(input int t, input int l, input instr_t w);
    @(negedge clk);
    checkPending();
    inValid     = 1'b0;
    pend        = 0;
    ctxWrEn     = 1'b1;
    ctxWrThread = TH_W'(t);
    ctxWrLayer  = LY_W'(l);
    ctxWrData   = w;
    mCtx[t][l]  = w;
  endtask

  task automatic loadAll(input int t, input instr_t w);
    for (int l = 0; l < LAYERS; l++) loadCtx(t, l, w);
  endtask

  function automatic int valAt(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 127;
      4: return 128;
      5: return 254;
      6: return 255;
      default: return 51;
    endcase
  endfunction

  task automatic sweep();
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        issue(0, valAt(i), valAt(j));
        issue(1, valAt(j), valAt(i));
      end
  endtask

  function automatic logic [31:0] nextRnd(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    instr_t w;
    logic [63:0] bits64;
    for (int t = 0; t < THREADS; t++) begin
      mIp[t] = 0;
      for (int l = 0; l < LAYERS; l++) mCtx[t][l] = '0;
      for (int e = 0; e < RF_DEPTH; e++) mRf[t][e] = 0;
    end
    lastOut = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    check(outPixel == '0, "R1 outPixel in reset", int'(outPixel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(outLast == 1'b0, "R1 outLast after reset", int'(outLast), 0);
    check(outPixel == '0, "R1 outPixel after reset", int'(outPixel), 0);
    forceTag = "R1 zero context passes pixel";
    issue(0, 90, 7);
    issue(1, 200, 3);
    issue(0, 255, 0);
    issue(1, 0, 255);
    forceTag = "";

    // R2: write one layer of thread 1 only, step thread 1 across all layers
    w = '0;
    w.cmpOp = CMP_MAX; w.cmpA = SRC_PIX; w.cmpB = SRC_AUX;
    loadCtx(1, 2, w);
    forceTag = "R2 single layer written";
    for (int k = 0; k < 8; k++) issue(1, 10 + k, 40);
    issue(0, 33, 99);
    forceTag = "";

    // R5: comparator sweep, operands swapped between threads
    for (int op = 0; op < 8; op++) begin
      w = '0; w.outSel = 2'(FU_CMP); w.cmpOp = 3'(op); w.cmpA = SRC_PIX; w.cmpB = SRC_AUX;
      loadAll(0, w);
      w.cmpA = SRC_AUX; w.cmpB = SRC_PIX;
      loadAll(1, w);
      sweep();
    end

    // R6: both ALUs
    for (int op = 0; op < 4; op++) begin
      w = '0; w.outSel = 2'(FU_ALU0); w.alu0Op = 2'(op); w.alu0A = SRC_PIX; w.alu0B = SRC_AUX;
      loadAll(0, w);
      w = '0; w.outSel = 2'(FU_ALU1); w.alu1Op = 2'(op); w.alu1A = SRC_AUX; w.alu1B = SRC_PIX;
      loadAll(1, w);
      sweep();
    end

    // R7: multiplier shifts
    for (int sh = 0; sh < 8; sh++) begin
      w = '0; w.outSel = 2'(FU_MUL); w.mulSh = 3'(sh); w.mulA = SRC_PIX; w.mulB = SRC_AUX;
      loadAll(0, w);
      loadAll(1, w);
      sweep();
    end

    // R9: write-back timing and bank isolation
    w = '0; w.wrEn = 1'b1; w.wrAddr = 4'd5; w.wrSel = 2'(FU_ALU0);
    w.alu0Op = ALU_ADDS; w.alu0A = SRC_PIX; w.alu0B = SRC_AUX;
    w.outSel = 2'(FU_CMP); w.cmpOp = CMP_MAX; w.cmpA = SRC_RFA; w.cmpB = SRC_RFA; w.raA = 4'd5;
    loadCtx(0, 0, w);
    w = '0; w.outSel = 2'(FU_ALU1); w.alu1Op = ALU_ADDS; w.alu1A = SRC_RFA; w.alu1B = SRC_PIX; w.raA = 4'd5;
    loadCtx(0, 1, w);
    w = '0; w.wrEn = 1'b1; w.wrAddr = 4'd6; w.wrSel = 2'(FU_CMP); w.cmpA = SRC_PIX; w.cmpB = SRC_PIX;
    w.outSel = 2'(FU_ALU0); w.alu0Op = ALU_XOR; w.alu0A = SRC_RFA; w.alu0B = SRC_AUX; w.raA = 4'd6;
    loadCtx(0, 2, w);
    w = '0; w.outSel = 2'(FU_CMP); w.cmpOp = CMP_MAX; w.cmpA = SRC_RFA; w.cmpB = SRC_RFB; w.raA = 4'd5; w.raB = 4'd6;
    loadCtx(0, 3, w);
    loadAll(1, w);
    while (mIp[0] != 0) issue(0, 1, 1);
    while (mIp[1] != 0) issue(1, 1, 1);
    forceTag = "R9 write-back and bank isolation";
    for (int k = 0; k < 6; k++) begin
      issue(0, 20 + k * 30, 9 + k);
      issue(1, 3, 4);
      issue(0, 77 - k, 5);
      issue(0, 11 * k, 200);
      issue(1, 8, 8);
      issue(0, 60, 61);
    end

    // R4: operand sources from aux and bank entry B
    w = '0; w.outSel = 2'(FU_ALU0); w.alu0Op = ALU_XOR; w.alu0A = SRC_AUX; w.alu0B = SRC_RFB; w.raB = 4'd5;
    loadAll(0, w);
    forceTag = "R4 aux and bank B operands";
    for (int k = 0; k < 8; k++) issue(0, 0, 16 * k + 3);

    // R10: idle cycles with context writes in between, then resume
    forceTag = "R10 resume after idle";
    issue(0, 1, 2);
    idleCycle();
    idleCycle();
    loadCtx(1, 0, '0);
    idleCycle();
    issue(0, 5, 6);
    issue(0, 7, 8);
    forceTag = "";

    // random programs on uneven interleaving
    for (int round = 0; round < 8; round++) begin
      for (int t = 0; t < THREADS; t++)
        for (int l = 0; l < LAYERS; l++) begin
          rnd = nextRnd(rnd); bits64[63:32] = rnd;
          rnd = nextRnd(rnd); bits64[31:0] = rnd;
          w = instr_t'(bits64[INSTR_W-1:0]);
          loadCtx(t, l, w);
        end
      for (int k = 0; k < 160; k++) begin
        rnd = nextRnd(rnd);
        if (rnd[2:0] == 3'd0) idleCycle();
        else issue(int'(rnd[3]), int'(rnd[15:8]), int'(rnd[23:16]));
      end
    end

    idleCycle();
    idleCycle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule